// File: doc/BRIEF.md
# Polled Port Status Sequencer

This block runs the transmit-side status polling toward a physical-layer device that holds one FIFO per port. A free-running counter steps through the configured port numbers, one each clock, and drives the current number on the polling address output. The device answers on a single status line one clock later. A high answer means the polled FIFO has at least a preset minimum of free space. A low answer means it is full or close to full. The block pairs each answer with the address that was issued one cycle earlier and stores it in a table that holds one bit per port.

A second source feeds the same table. While a burst goes to one port, the device reports that port's space on a selected-status line. When the selected-port qualifier is high, this report overwrites the entry of the selected port. Polling keeps running at the same time for the other ports. A parameter chooses which sources are active: polled only, selected only, or both combined. The transmit scheduler reads the table through a combinational port that is indexed by port number. The table clears to "no space" at reset, so no port is eligible until its first valid report arrives.

Top module: `poll_status_seq`

## Requirements
- R1: While reset is asserted, `tadr` is 0 and every table entry reads 0 (no space).
- R2: After reset, `tadr` starts at 0 and increases by one on every clock. After NUM_PORTS-1 it wraps to 0. It never reaches NUM_PORTS, and the bits above the port index are 0.
- R3: The value of `ptpa` sampled at a clock edge is written into the entry of the address that `tadr` presented during the previous cycle. It becomes readable after that edge.
- R4: At the first clock edge after reset is released, `ptpa` is not written to any entry, because no address has yet been presented for a whole cycle.
- R5: An entry keeps its value between writes, whatever the level of `ptpa` while other ports are polled.
- R6: In combined mode, when `sel_valid` is 1 at a clock edge and `sel_port` < NUM_PORTS, the value of `stpa` is written into entry `sel_port`. It is readable after that edge.
- R7: When the polled write and the selected write target the same entry at the same edge, the selected value (`stpa`) is stored.
- R8: A `sel_port` value of NUM_PORTS or more causes no write. A `rd_port` value of NUM_PORTS or more reads 0.
- R9: In polled-only mode, `sel_valid`, `sel_port` and `stpa` have no effect on the table.
- R10: `rd_space` shows entry `rd_port` combinationally, in the same cycle that `rd_port` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tadr | output | PADDR_W | Polling address presented to the device |
| ptpa | input | 1 | Polled space answer for the address of the previous cycle |
| sel_valid | input | 1 | Qualifies `stpa` for the port currently being transferred |
| sel_port | input | PADDR_W | Port currently selected for transfer |
| stpa | input | 1 | Space status of the selected port |
| rd_port | input | PADDR_W | Scheduler read index |
| rd_space | output | 1 | Stored status of entry `rd_port` |

## Verification
Two instances are exercised side by side: a 4-port combined instance and an 8-port polled-only instance. The device model answers from a space pattern that the bench changes over time. A fixed irregular pattern shows whether the answer lands on the delayed address rather than the current one. A pattern that inverts on every cycle shows whether the wrong cycle's answer is captured and whether entries hold between their polls. Selected-status pulses are aimed at idle entries, at the entry being polled in that same cycle, and at out-of-range port numbers. These separate the write priority, the range guard, and the polled-only instance's indifference to the selected inputs. Every entry and several out-of-range indices are read back every cycle through the scheduler port.

// File: rtl/poll_status_pkg.sv
`timescale 1ns/1ps
package poll_status_pkg;

   // which status sources may write the table
   typedef enum logic [1:0] {
      SRC_POLLED   = 2'd0,
      SRC_SELECTED = 2'd1,
      SRC_COMBINED = 2'd2
   } stat_src_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/poll_addr_gen.sv
`timescale 1ns/1ps
module poll_addr_gen #(
   parameter int NUM_PORTS = 4,
   parameter int IDX_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [IDX_W-1:0] cur_idx,
   output logic [IDX_W-1:0] prev_idx,
   output logic             prev_vld
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_PORTS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_idx  <= '0;
         prev_idx <= '0;
         prev_vld <= 1'b0;
      end else begin
         cur_idx  <= (cur_idx == LAST) ? '0 : cur_idx + IDX_W'(1);
         prev_idx <= cur_idx;
         prev_vld <= 1'b1;
      end
   end
endmodule

// File: rtl/status_table.sv
`timescale 1ns/1ps
module status_table #(
   parameter int NUM_PORTS = 4,
   parameter int IDX_W     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 poll_we,
   input  logic [IDX_W-1:0]     poll_idx,
   input  logic                 poll_val,
   input  logic                 sel_we,
   input  logic [IDX_W-1:0]     sel_idx,
   input  logic                 sel_val,
   output logic [NUM_PORTS-1:0] entries
);
   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_ent
      logic poll_hit;
      logic sel_hit;
      logic bit_q;

      assign poll_hit = poll_we && (poll_idx == IDX_W'(i));
      assign sel_hit  = sel_we  && (sel_idx  == IDX_W'(i));

      // selected report is the fresher one, so it wins a collision
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        bit_q <= 1'b0;
         else if (sel_hit)  bit_q <= sel_val;
         else if (poll_hit) bit_q <= poll_val;
      end

      assign entries[i] = bit_q;
   end
endmodule

// File: rtl/status_read.sv
`timescale 1ns/1ps
module status_read #(
   parameter int NUM_PORTS = 4,
   parameter int PADDR_W   = 4
) (
   input  logic [NUM_PORTS-1:0] entries,
   input  logic [PADDR_W-1:0]   rd_port,
   output logic                 rd_space
);
   always_comb begin
      rd_space = 1'b0;
      for (int i = 0; i < NUM_PORTS; i++) begin
         if (rd_port == PADDR_W'(i)) rd_space = entries[i];
      end
   end
endmodule

// File: rtl/poll_status_seq.sv
`timescale 1ns/1ps
module poll_status_seq #(
   parameter int                        NUM_PORTS = 4,
   parameter int                        PADDR_W   = 4,
   parameter poll_status_pkg::stat_src_e SRC      = poll_status_pkg::SRC_COMBINED
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [PADDR_W-1:0] tadr,
   input  logic               ptpa,
   input  logic               sel_valid,
   input  logic [PADDR_W-1:0] sel_port,
   input  logic               stpa,
   input  logic [PADDR_W-1:0] rd_port,
   output logic               rd_space
);
   import poll_status_pkg::*;

   localparam int IDX_W = idx_width(NUM_PORTS);

   initial begin
      assert (NUM_PORTS == 1 || NUM_PORTS == 2 || NUM_PORTS == 4 || NUM_PORTS == 8)
         else $error("NUM_PORTS must be 1, 2, 4 or 8");
      assert ((1 << PADDR_W) > NUM_PORTS)
         else $error("PADDR_W too narrow for NUM_PORTS");
   end

   logic [IDX_W-1:0]     cur_idx;
   logic [IDX_W-1:0]     prev_idx;
   logic                 prev_vld;
   logic                 poll_we;
   logic                 sel_we;
   logic                 sel_ok;
   logic [NUM_PORTS-1:0] tab_q;

   poll_addr_gen #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .cur_idx  (cur_idx),
      .prev_idx (prev_idx),
      .prev_vld (prev_vld)
   );

   assign tadr   = PADDR_W'(cur_idx);
   assign sel_ok = sel_valid && (int'(sel_port) < NUM_PORTS);

   if (SRC == SRC_POLLED) begin : g_src_poll
      assign poll_we = prev_vld;
      assign sel_we  = 1'b0;
   end else if (SRC == SRC_SELECTED) begin : g_src_sel
      assign poll_we = 1'b0;
      assign sel_we  = sel_ok;
   end else begin : g_src_both
      assign poll_we = prev_vld;
      assign sel_we  = sel_ok;
   end

   status_table #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_tab (
      .clk      (clk),
      .rst_n    (rst_n),
      .poll_we  (poll_we),
      .poll_idx (prev_idx),
      .poll_val (ptpa),
      .sel_we   (sel_we),
      .sel_idx  (sel_port[IDX_W-1:0]),
      .sel_val  (stpa),
      .entries  (tab_q)
   );

   status_read #(.NUM_PORTS(NUM_PORTS), .PADDR_W(PADDR_W)) u_rd (
      .entries  (tab_q),
      .rd_port  (rd_port),
      .rd_space (rd_space)
   );
endmodule

// File: rtl/poll_status_seq_chk.sv
`timescale 1ns/1ps
module poll_status_seq_chk #(
   parameter int                        NUM_PORTS = 4,
   parameter int                        PADDR_W   = 4,
   parameter int                        IDX_W     = 2,
   parameter poll_status_pkg::stat_src_e SRC      = poll_status_pkg::SRC_COMBINED
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [PADDR_W-1:0]   tadr,
   input logic                 ptpa,
   input logic                 sel_valid,
   input logic [PADDR_W-1:0]   sel_port,
   input logic                 stpa,
   input logic [PADDR_W-1:0]   rd_port,
   input logic                 rd_space,
   input logic [NUM_PORTS-1:0] entries,
   input logic [IDX_W-1:0]     prev_idx,
   input logic                 prev_vld
);
   import poll_status_pkg::*;

   logic seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   logic sel_in_range;
   logic sel_on_poll;
   assign sel_in_range = (SRC != SRC_POLLED) && sel_valid && (int'(sel_port) < NUM_PORTS);
   assign sel_on_poll  = sel_in_range && (sel_port[IDX_W-1:0] == prev_idx);

   // R2: address always names a configured port
   a_r2_tadr_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(tadr) < NUM_PORTS);

   // R2: address advances by one per clock and wraps
   a_r2_tadr_step: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> int'(tadr) == (int'($past(tadr)) + 1) % NUM_PORTS);

   // R3: polled answer lands on the delayed address
   a_r3_poll_write: assert property (@(posedge clk) disable iff (!rst_n)
      (SRC != SRC_SELECTED && prev_vld && !sel_on_poll)
      |=> entries[$past(prev_idx)] == $past(ptpa));

   // R6, R7: selected report lands on the selected entry
   a_r6_sel_write: assert property (@(posedge clk) disable iff (!rst_n)
      sel_in_range |=> entries[$past(sel_port[IDX_W-1:0])] == $past(stpa));

   // R8: out-of-range read returns no space
   a_r8_rd_oob: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rd_port) >= NUM_PORTS) |-> !rd_space);
endmodule

bind poll_status_seq poll_status_seq_chk #(
   .NUM_PORTS (NUM_PORTS),
   .PADDR_W   (PADDR_W),
   .IDX_W     (IDX_W),
   .SRC       (SRC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tadr      (tadr),
   .ptpa      (ptpa),
   .sel_valid (sel_valid),
   .sel_port  (sel_port),
   .stpa      (stpa),
   .rd_port   (rd_port),
   .rd_space  (rd_space),
   .entries   (tab_q),
   .prev_idx  (prev_idx),
   .prev_vld  (prev_vld)
);

// File: tb/poll_status_seq_bench.sv
`timescale 1ns/1ps
module poll_status_seq_bench;
   localparam int PW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [PW-1:0] tadr_a, tadr_b;
   logic          ptpa_a, ptpa_b;
   logic          sel_valid = 1'b0;
   logic [PW-1:0] sel_port = '0;
   logic          stpa = 1'b0;
   logic [PW-1:0] rd_port = '0;
   logic          rd_a, rd_b;
   logic [7:0]    phy_space = 8'hFF;

   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   string tag = "R1";

   // behavioural model state: index 0 = 4-port combined, 1 = 8-port polled-only
   int         m_tadr [2];
   int         m_prev [2];
   bit         m_pv   [2];
   logic [7:0] m_tab  [2];

   always #5 clk = ~clk;

   poll_status_seq #(.NUM_PORTS(4), .PADDR_W(PW), .SRC(poll_status_pkg::SRC_COMBINED)) u_poll_status_seq (
      .clk(clk), .rst_n(rst_n), .tadr(tadr_a), .ptpa(ptpa_a), .sel_valid(sel_valid),
      .sel_port(sel_port), .stpa(stpa), .rd_port(rd_port), .rd_space(rd_a));

   poll_status_seq #(.NUM_PORTS(8), .PADDR_W(PW), .SRC(poll_status_pkg::SRC_POLLED)) u_poll_only (
      .clk(clk), .rst_n(rst_n), .tadr(tadr_b), .ptpa(ptpa_b), .sel_valid(sel_valid),
      .sel_port(sel_port), .stpa(stpa), .rd_port(rd_port), .rd_space(rd_b));

   // device model: answers for the address it sampled at the last edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptpa_a <= 1'b1;
         ptpa_b <= 1'b1;
      end else begin
         ptpa_a <= phy_space[tadr_a[2:0]];
         ptpa_b <= phy_space[tadr_b[2:0]];
      end
   end

   task automatic check(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int k = 0; k < 2; k++) begin
         m_tadr[k] = 0; m_prev[k] = 0; m_pv[k] = 1'b0; m_tab[k] = '0;
      end
   endtask

   task automatic model_step(input bit pa, input bit pb);
      for (int k = 0; k < 2; k++) begin
         int n = (k == 0) ? 4 : 8;
         if (m_pv[k]) m_tab[k][m_prev[k]] = (k == 0) ? pa : pb;
         if (k == 0 && sel_valid && int'(sel_port) < n) m_tab[0][sel_port] = stpa;
         m_prev[k] = m_tadr[k];
         m_pv[k]   = 1'b1;
         m_tadr[k] = (m_tadr[k] + 1) % n;
      end
   endtask

   task automatic compare_all();
      check(tadr_a === PW'(m_tadr[0]), {tag, " R2 tadr 4-port"}, int'(tadr_a), m_tadr[0]);
      check(tadr_b === PW'(m_tadr[1]), {tag, " R2 tadr 8-port"}, int'(tadr_b), m_tadr[1]);
      for (int p = 0; p < 10; p++) begin
         logic ea, eb;
         rd_port = PW'(p);
         #0.4;
         ea = (p < 4) ? m_tab[0][p] : 1'b0;
         eb = (p < 8) ? m_tab[1][p] : 1'b0;
         check(rd_a === ea, $sformatf("%s R10 R8 4-port entry %0d", tag, p), int'(rd_a), int'(ea));
         check(rd_b === eb, $sformatf("%s R9 R10 8-port entry %0d", tag, p), int'(rd_b), int'(eb));
      end
   endtask

   task automatic cycle(input bit sv, input int sp, input bit st);
      bit pa, pb;
      sel_valid = sv;
      sel_port  = PW'(sp);
      stpa      = st;
      pa = ptpa_a;
      pb = ptpa_b;
      @(posedge clk);
      model_step(pa, pb);
      @(negedge clk);
      compare_all();
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      for (int c = 0; c < 20000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      tag = "R1";
      compare_all();
      rst_n = 1'b1;

      // R4: device line is high, but nothing was polled for a full cycle yet
      tag = "R4";
      cycle(0, 0, 0);
      check(m_tab[0][0] == 1'b0, "R4 model entry 0 untouched", int'(m_tab[0][0]), 0);

      tag = "R3";
      phy_space = 8'b1011_0110;
      for (int i = 0; i < 12; i++) cycle(0, 0, 0);

      tag = "R5";
      for (int i = 0; i < 12; i++) begin
         phy_space = ~phy_space;
         cycle(0, 0, 0);
      end

      // R6 / R9: selected report on an idle entry
      tag = "R6";
      phy_space = 8'h00;
      repeat (9) cycle(0, 0, 0);
      cycle(1, 2, 1);
      cycle(0, 0, 0);
      cycle(1, 5, 1);
      cycle(1, 1, 1);
      cycle(1, 1, 0);
      repeat (3) cycle(0, 0, 0);

      // R7: selected report aimed at the entry being polled this edge
      tag = "R7";
      for (int i = 0; i < 8; i++) cycle(1, m_prev[0], (i % 2) == 0);

      // R8: out-of-range selected ports
      tag = "R8";
      phy_space = 8'hFF;
      for (int i = 0; i < 6; i++) cycle(1, (i % 2) ? 9 : 4, 0);

      tag = "R3";
      phy_space = 8'b0101_1100;
      for (int i = 0; i < 16; i++) cycle(0, 0, 0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule